// File: doc/BRIEF.md
# I2C Mode and Condition Control

This block is the command layer of a combined master/slave I2C port. A register-style write port carries four command bits: a master-select value, a repeated-START request, an acknowledge-enable value and an interrupt-flag value. The block turns accepted writes into START, repeated START and STOP sequences on open-drain SCL/SDA lines. It also decides whether SDA is pulled low during the ninth clock of a received byte. A neighbouring byte shifter, which is not part of this block, reports byte completion, transfer direction, address acknowledge, arbitration loss, slave activity and the ninth-clock window through input strobes and levels.

A small phase sequencer drives the lines. Each phase lasts `half_period` clock cycles. A detector watches the resolved bus lines and keeps a busy flag, whichever party produced the condition. The interrupt flag gates the commands that end or restart a transfer. Conflicting writes and arbitration loss follow fixed rules, listed below.

Top module: `i2c_mode_ctrl`

## Requirements
- R1: After reset, `master`, `bus_busy`, `int_flag`, `arb_flag`, `cmd_err`, `ack_en`, `scl_oe` and `sda_oe` are all 0.
- R2: A write with `wr_mst`=1 while `master`=0, `bus_busy`=0 and `slave_active`=0 sets `master` and produces a START. SDA is pulled low while SCL is released, and SCL is pulled low exactly `half_period` cycles later. SCL is then held low.
- R3: A write with `wr_mst`=0 while `master`=1 and `int_flag`=1 clears `master` and produces a STOP (SDA rises while SCL is high). Afterwards both lines are released.
- R4: A write with `wr_rsta`=1 and `wr_mst`=1 while `master`=1 and `int_flag`=1 produces a repeated START, with no STOP and with `master` staying 1.
- R5: While `int_flag`=0, a write of `wr_rsta`=1 or of `wr_mst`=0 produces no bus condition and leaves `master` unchanged.
- R6: A `byte_done` pulse sets `int_flag`. A write with `wr_intf`=0 clears it. When that write also requests a repeated START or a STOP, the condition is still produced.
- R7: A write with `wr_rsta`=1 and `wr_mst`=0 is rejected whole: no condition, `master` and `int_flag` unchanged, and `cmd_err`=1. The next write without that combination clears `cmd_err`.
- R8: An `arb_loss` pulse while `master`=1 clears `master`, sets `arb_flag` and releases both lines. `arb_flag` clears when the next START is accepted.
- R9: A write with `wr_mst`=1 while `slave_active`=1 is ignored: `master` stays 0, no START, and `arb_flag` is unchanged.
- R10: While `master`=1 and `ack_slot`=1, `sda_oe` is 1 exactly when `ack_en`=1 and `rx_dir`=1 (receiving).
- R11: While `master`=0 and `ack_slot`=1, `sda_oe` is 1 only when `ack_en`=1 and an `addr_ack` pulse has come since the last START or STOP seen on the bus.
- R12: `bus_busy` is set after any START on the bus and cleared after any STOP, including conditions produced by another device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | DIV_W | Cycles per line phase (0 acts as 1) |
| wr_en | input | 1 | Command write strobe |
| wr_mst | input | 1 | Master-select value written |
| wr_rsta | input | 1 | Repeated-START request written |
| wr_acken | input | 1 | Acknowledge-enable value written |
| wr_intf | input | 1 | Interrupt-flag value written (0 clears) |
| byte_done | input | 1 | Shifter pulse: byte finished, sets interrupt flag |
| rx_dir | input | 1 | Shifter level: 1 when this port receives data |
| addr_ack | input | 1 | Shifter pulse: slave address was acknowledged |
| arb_loss | input | 1 | Shifter pulse: arbitration lost |
| slave_active | input | 1 | Shifter level: slave transfer in progress |
| ack_slot | input | 1 | Shifter level: ninth clock of a byte in progress |
| scl_in | input | 1 | Resolved SCL line |
| sda_in | input | 1 | Resolved SDA line |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| master | output | 1 | Master mode selected |
| bus_busy | output | 1 | Bus busy flag |
| int_flag | output | 1 | Interrupt/wait flag |
| arb_flag | output | 1 | Arbitration was lost |
| cmd_err | output | 1 | Last write was a rejected conflicting command |
| ack_en | output | 1 | Acknowledge enable |

## Verification
The assertions assume that `arb_loss`, `byte_done` and `addr_ack` are single-cycle pulses. They also assume that the shifter raises `byte_done` only while no condition sequence is running, so a repeated START or STOP always finds the sequencer holding SCL low. The stimulus keeps to this by issuing every command through one write task and pulsing the shifter strobes only after the bench's own line monitor has seen the preceding sequence finish. Random writes touch only the acknowledge-enable and direction bits while the block sits in a stable master or slave state.

// File: rtl/i2c_mc_pkg.sv
package i2c_mc_pkg;
   typedef enum logic [3:0] {
      PH_IDLE, PH_S1, PH_S2, PH_HOLD,
      PH_R1, PH_R2, PH_R3, PH_R4,
      PH_P1, PH_P2, PH_P3
   } phase_e;

   typedef struct packed {
      logic start;
      logic rstart;
      logic stop;
   } cond_req_t;
endpackage

// File: rtl/i2c_mc_regs.sv
module i2c_mc_regs
   import i2c_mc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_en,
   input  logic      wr_mst,
   input  logic      wr_rsta,
   input  logic      wr_acken,
   input  logic      wr_intf,
   input  logic      byte_done,
   input  logic      arb_loss,
   input  logic      slave_active,
   input  logic      bus_busy,
   input  logic      eng_idle,
   input  logic      eng_hold,
   output logic      master,
   output logic      int_flag,
   output logic      arb_flag,
   output logic      cmd_err,
   output logic      ack_en,
   output cond_req_t req
);
   logic mst_q, int_q, arb_q, err_q, acken_q;
   logic conflict, accept, lost, go_start, go_stop, go_rsta;

   always_comb begin
      conflict = wr_en & wr_rsta & ~wr_mst;
      accept   = wr_en & ~conflict;
      lost     = arb_loss & mst_q;
      go_start = accept & wr_mst & ~mst_q & ~bus_busy & ~slave_active & eng_idle;
      go_stop  = accept & ~wr_mst & mst_q & int_q & bus_busy & eng_hold & ~lost;
      go_rsta  = accept & wr_rsta & wr_mst & mst_q & int_q & eng_hold & ~lost;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst_q   <= 1'b0;
         int_q   <= 1'b0;
         arb_q   <= 1'b0;
         err_q   <= 1'b0;
         acken_q <= 1'b0;
         req     <= '0;
      end else begin
         if (lost)          mst_q <= 1'b0;
         else if (go_start) mst_q <= 1'b1;
         else if (go_stop)  mst_q <= 1'b0;

         if (lost)          arb_q <= 1'b1;
         else if (go_start) arb_q <= 1'b0;

         if (byte_done)                int_q <= 1'b1;
         else if (accept && !wr_intf)  int_q <= 1'b0;

         if (wr_en)  err_q   <= conflict;
         if (accept) acken_q <= wr_acken;

         req.start  <= go_start;
         req.rstart <= go_rsta;
         req.stop   <= go_stop;
      end
   end

   assign master   = mst_q;
   assign int_flag = int_q;
   assign arb_flag = arb_q;
   assign cmd_err  = err_q;
   assign ack_en   = acken_q;

   // R2
   start_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req.start |-> mst_q);
   // R8
   arb_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arb_loss && mst_q |=> !mst_q && arb_q);
   // R7
   conflict_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_rsta && !wr_mst && !arb_loss |=> $stable(mst_q) && err_q);
   // R5
   gated_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !int_q && !wr_mst && mst_q && !arb_loss |=> mst_q);
   // R9
   slave_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && slave_active && !mst_q |=> !mst_q && $stable(arb_q));
endmodule

// File: rtl/i2c_mc_seq.sv
module i2c_mc_seq
   import i2c_mc_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] half_period,
   input  cond_req_t        req,
   input  logic             abort,
   output logic             scl_low,
   output logic             sda_low,
   output logic             idle,
   output logic             hold
);
   if (DIV_W < 2 || DIV_W > 16) begin : g_bad_div_w
      $error("i2c_mc_seq: DIV_W must be within 2..16");
   end

   phase_e           ph;
   logic [DIV_W-1:0] tmr;
   logic [DIV_W-1:0] load_val;

   assign load_val = (half_period == '0) ? '0 : half_period - 1'b1;

   function automatic phase_e next_ph(input phase_e p);
      case (p)
         PH_S1:   return PH_S2;
         PH_S2:   return PH_HOLD;
         PH_R1:   return PH_R2;
         PH_R2:   return PH_R3;
         PH_R3:   return PH_R4;
         PH_R4:   return PH_HOLD;
         PH_P1:   return PH_P2;
         PH_P2:   return PH_P3;
         default: return PH_IDLE;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         tmr <= '0;
      end else if (abort) begin
         ph  <= PH_IDLE;
         tmr <= '0;
      end else begin
         case (ph)
            PH_IDLE: if (req.start) begin
               ph  <= PH_S1;
               tmr <= load_val;
            end
            PH_HOLD: if (req.rstart) begin
               ph  <= PH_R1;
               tmr <= load_val;
            end else if (req.stop) begin
               ph  <= PH_P1;
               tmr <= load_val;
            end
            default: if (tmr == '0) begin
               ph  <= next_ph(ph);
               tmr <= load_val;
            end else begin
               tmr <= tmr - 1'b1;
            end
         endcase
      end
   end

   always_comb begin
      scl_low = ph inside {PH_S2, PH_HOLD, PH_R1, PH_R4, PH_P1};
      sda_low = ph inside {PH_S1, PH_S2, PH_R3, PH_R4, PH_P1, PH_P2};
      idle    = (ph == PH_IDLE);
      hold    = (ph == PH_HOLD);
   end

   // R2
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req.start, req.rstart, req.stop}));
   // R2
   start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req.start && ph == PH_IDLE && !abort |=> sda_low && !scl_low);
   // R3
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph == PH_P3 && tmr == '0 && !abort |=> !sda_low && !scl_low);
   // R8
   abort_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !sda_low && !scl_low);
endmodule

// File: rtl/i2c_mc_det.sv
module i2c_mc_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic start_det,
   output logic stop_det,
   output logic busy
);
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("i2c_mc_det: SYNC_STAGES must be within 0..3");
   end

   logic scl_s, sda_s, scl_p, sda_p, busy_q;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign scl_s = scl_in;
      assign sda_s = sda_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
         end else begin
            scl_sh[0] <= scl_in;
            sda_sh[0] <= sda_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               scl_sh[i] <= scl_sh[i-1];
               sda_sh[i] <= sda_sh[i-1];
            end
         end
      end
      assign scl_s = scl_sh[SYNC_STAGES-1];
      assign sda_s = sda_sh[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
         busy_q <= 1'b0;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
         if (start_det)     busy_q <= 1'b1;
         else if (stop_det) busy_q <= 1'b0;
      end
   end

   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
   assign busy      = busy_q;

   // R12
   busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> busy_q);
   // R12
   busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det && !start_det |=> !busy_q);
endmodule

// File: rtl/i2c_mode_ctrl.sv
module i2c_mode_ctrl
   import i2c_mc_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] half_period,
   input  logic             wr_en,
   input  logic             wr_mst,
   input  logic             wr_rsta,
   input  logic             wr_acken,
   input  logic             wr_intf,
   input  logic             byte_done,
   input  logic             rx_dir,
   input  logic             addr_ack,
   input  logic             arb_loss,
   input  logic             slave_active,
   input  logic             ack_slot,
   input  logic             scl_in,
   input  logic             sda_in,
   output logic             scl_oe,
   output logic             sda_oe,
   output logic             master,
   output logic             bus_busy,
   output logic             int_flag,
   output logic             arb_flag,
   output logic             cmd_err,
   output logic             ack_en
);
   cond_req_t req;
   logic eng_idle, eng_hold, eng_scl_low, eng_sda_low;
   logic start_det, stop_det, addr_ackd, ack_drive;

   i2c_mc_regs u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_mst(wr_mst), .wr_rsta(wr_rsta),
      .wr_acken(wr_acken), .wr_intf(wr_intf),
      .byte_done(byte_done), .arb_loss(arb_loss),
      .slave_active(slave_active), .bus_busy(bus_busy),
      .eng_idle(eng_idle), .eng_hold(eng_hold),
      .master(master), .int_flag(int_flag), .arb_flag(arb_flag),
      .cmd_err(cmd_err), .ack_en(ack_en), .req(req)
   );

   i2c_mc_seq #(.DIV_W(DIV_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .half_period(half_period),
      .req(req), .abort(arb_loss & master),
      .scl_low(eng_scl_low), .sda_low(eng_sda_low),
      .idle(eng_idle), .hold(eng_hold)
   );

   i2c_mc_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .start_det(start_det), .stop_det(stop_det), .busy(bus_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    addr_ackd <= 1'b0;
      else if (start_det | stop_det) addr_ackd <= 1'b0;
      else if (addr_ack & ~master)   addr_ackd <= 1'b1;
   end

   assign ack_drive = ack_en & (master ? rx_dir : addr_ackd);
   assign scl_oe    = eng_scl_low;
   assign sda_oe    = eng_sda_low | (ack_slot & ack_drive);

   // R10
   ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_en && !eng_sda_low |-> !sda_oe);
   // R11
   slave_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !addr_ackd);
endmodule

// File: tb/i2c_mode_ctrl_test.sv
module i2c_mode_ctrl_test;
   localparam int DW = 8;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [DW-1:0] half_period = 8'd3;
   logic wr_en = 0, wr_mst = 0, wr_rsta = 0, wr_acken = 0, wr_intf = 0;
   logic byte_done = 0, rx_dir = 0, addr_ack = 0, arb_loss = 0;
   logic slave_active = 0, ack_slot = 0, tb_sda_low = 0;
   logic scl_oe, sda_oe, master, bus_busy, int_flag, arb_flag, cmd_err, ack_en;
   logic scl_bus, sda_bus;

   assign scl_bus = ~scl_oe;
   assign sda_bus = ~(sda_oe | tb_sda_low);

   i2c_mode_ctrl #(.DIV_W(DW), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .half_period(half_period),
      .wr_en(wr_en), .wr_mst(wr_mst), .wr_rsta(wr_rsta),
      .wr_acken(wr_acken), .wr_intf(wr_intf),
      .byte_done(byte_done), .rx_dir(rx_dir), .addr_ack(addr_ack),
      .arb_loss(arb_loss), .slave_active(slave_active), .ack_slot(ack_slot),
      .scl_in(scl_bus), .sda_in(sda_bus),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .master(master), .bus_busy(bus_busy),
      .int_flag(int_flag), .arb_flag(arb_flag), .cmd_err(cmd_err), .ack_en(ack_en)
   );

   always #2 clk = ~clk;

   int checks = 0, fails = 0;
   bit done = 0;
   int cyc = 0, starts = 0, stops = 0, gap = -1, t_fall = 0;
   bit scl_p = 1, sda_p = 1, pend = 0;

   // independent bus monitor, sampled away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (scl_bus && scl_p && sda_p && !sda_bus) begin
            starts++; t_fall = cyc; pend = 1;
         end
         if (scl_bus && scl_p && !sda_p && sda_bus) stops++;
         if (pend && scl_p && !scl_bus) begin
            gap = cyc - t_fall; pend = 0;
         end
      end
      scl_p = scl_bus;
      sda_p = sda_bus;
   end

   function automatic bit exp_ack(bit mst, bit aen, bit rx, bit addr_seen);
      return aen && (mst ? rx : addr_seen);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic ceq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic wr(input bit m, input bit r, input bit a, input bit i);
      @(negedge clk);
      wr_en = 1; wr_mst = m; wr_rsta = r; wr_acken = a; wr_intf = i;
      @(negedge clk);
      wr_en = 0; wr_mst = 0; wr_rsta = 0; wr_acken = 0; wr_intf = 0;
   endtask

   task automatic pulse_done();
      @(negedge clk); byte_done = 1;
      @(negedge clk); byte_done = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_starts(input int n);
      for (int k = 0; k < 300 && starts < n; k++) @(negedge clk);
      idle(12);
   endtask

   task automatic wait_stops(input int n);
      for (int k = 0; k < 300 && stops < n; k++) @(negedge clk);
      idle(12);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h5eed);
      idle(3);
      // R1 reset state
      ceq("R1 master", master, 0);
      ceq("R1 busy", bus_busy, 0);
      ceq("R1 lines", {scl_oe, sda_oe, int_flag, arb_flag, cmd_err, ack_en}, 0);
      rst_n = 1;
      idle(3);

      // R2 START from idle with H=3
      wr(1, 0, 1, 1);
      wait_starts(1);
      ceq("R2 starts", starts, 1);
      ceq("R2 master", master, 1);
      ceq("R2 gap", gap, 3);
      ceq("R2 scl held", scl_oe, 1);
      ceq("R12 busy after own START", bus_busy, 1);

      // R5 ignored while int flag clear
      wr(0, 0, 1, 1);
      idle(30);
      ceq("R5 master kept", master, 1);
      ceq("R5 no stop", stops, 0);
      wr(1, 1, 1, 1);
      idle(30);
      ceq("R5 no restart", starts, 1);

      // R6 / R4 repeated START with simultaneous int clear
      pulse_done();
      ceq("R6 int set", int_flag, 1);
      wr(1, 1, 1, 0);
      wait_starts(2);
      ceq("R4 restart seen", starts, 2);
      ceq("R4 no stop", stops, 0);
      ceq("R4 master", master, 1);
      ceq("R6 int cleared", int_flag, 0);

      // R7 conflicting write
      pulse_done();
      wr(0, 1, 1, 1);
      ceq("R7 err", cmd_err, 1);
      ceq("R7 master", master, 1);
      idle(30);
      ceq("R7 no cond", starts * 10 + stops, 20);
      ceq("R7 int kept", int_flag, 1);
      wr(1, 0, 1, 1);
      ceq("R7 err cleared", cmd_err, 0);

      // R10 master acknowledge
      rx_dir = 1; ack_slot = 1;
      idle(1);
      ceq("R10 ack rx en", sda_oe, 1);
      wr(1, 0, 0, 1);
      ceq("R10 ack disabled", sda_oe, 0);
      for (int k = 0; k < 16; k++) begin
         bit a, r;
         a = 1'($urandom); r = 1'($urandom);
         rx_dir = r;
         wr(1, 0, a, 1);
         ceq("R10 random ack", sda_oe, exp_ack(1, a, r, 0));
      end
      ack_slot = 0; rx_dir = 0;

      // R3 STOP with int clear
      wr(0, 0, 1, 0);
      wait_stops(1);
      ceq("R3 stop seen", stops, 1);
      ceq("R3 master", master, 0);
      ceq("R3 released", {scl_oe, sda_oe}, 0);
      ceq("R12 busy cleared", bus_busy, 0);
      ceq("R6 int cleared by stop write", int_flag, 0);

      // R12 external START, R11 slave ack, R9 slave write
      tb_sda_low = 1;
      idle(10);
      ceq("R12 ext busy", bus_busy, 1);
      ack_slot = 1;
      idle(1);
      ceq("R11 no addr ack", sda_oe, 0);
      @(negedge clk); addr_ack = 1; @(negedge clk); addr_ack = 0;
      ceq("R11 after addr ack", sda_oe, 1);
      ack_slot = 0;
      slave_active = 1;
      wr(1, 0, 1, 1);
      idle(20);
      ceq("R9 master stays 0", master, 0);
      ceq("R9 arb unchanged", arb_flag, 0);
      ceq("R9 no start", starts, 3);
      slave_active = 0;
      tb_sda_low = 0;
      idle(10);
      ceq("R12 ext stop", bus_busy, 0);
      ack_slot = 1;
      idle(1);
      ceq("R11 cleared by stop", sda_oe, 0);
      ack_slot = 0;

      // R8 arbitration loss
      wr(1, 0, 1, 1);
      wait_starts(4);
      ceq("R8 master before", master, 1);
      @(negedge clk); arb_loss = 1; @(negedge clk); arb_loss = 0;
      ceq("R8 master cleared", master, 0);
      ceq("R8 flag", arb_flag, 1);
      idle(2);
      ceq("R8 released", {scl_oe, sda_oe}, 0);
      tb_sda_low = 1; idle(10); tb_sda_low = 0; idle(10);
      ceq("R12 busy after ext pair", bus_busy, 0);
      wr(1, 0, 1, 1);
      wait_starts(6);
      ceq("R8 flag cleared", arb_flag, 0);
      pulse_done();
      wr(0, 0, 1, 0);
      wait_stops(3);

      // R2 random half-period timing
      for (int k = 0; k < 4; k++) begin
         int h, s0, p0;
         h = 1 + int'($urandom % 6);
         half_period = DW'(h);
         s0 = starts; p0 = stops;
         wr(1, 0, 1, 1);
         wait_starts(s0 + 1);
         ceq("R2 random gap", gap, h);
         pulse_done();
         wr(0, 0, 1, 0);
         wait_stops(p0 + 1);
         ceq("R3 random stop", {master, bus_busy}, 0);
      end
      finish_run();
   end
endmodule